// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a processor core and a data memory one word wide. For a load it receives the low bits of the effective address, the access size, a signed/unsigned flag and the fetched memory word. It returns the addressed byte, halfword or word, right-aligned and extended to the full register width. For a store it receives the same address bits, the size and the register value. It returns write data and per-lane write strobes for the memory.

Lanes follow big-endian order. Address offset 0 names the most significant byte of the word, and strobe bit 3 belongs to offset 0. An access whose address is not a multiple of its size is flagged as misaligned. The same flag covers the reserved size code. A flagged access produces no strobes and no load data. All results are registered and appear one clock after the request.

Top module: `lsu_align_unit`

## Requirements
- R1: While reset is asserted (active-low `rst_n`), every output is zero.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. After a cycle with `req_valid` low, every output is zero.
- R3: Size code 0 is a byte access. An unsigned byte load returns the byte at offset k, taken from word bits [31-8k:24-8k], zero-extended to 32 bits.
- R4: A signed byte or halfword load (`req_signed`=1) copies the loaded value's top bit into all upper result bits.
- R5: Size code 1 is a halfword access. A halfword load at offset 0 returns word bits [31:16], and at offset 2 returns bits [15:0]. The result is extended according to R4.
- R6: Size code 2 is a word access. A word load at offset 0 returns the memory word unchanged, whatever the value of `req_signed`.
- R7: A byte store drives exactly one strobe, bit (3-k) for offset k, and repeats register bits [7:0] in every byte lane of the write data.
- R8: A halfword store drives strobes 4'b1100 at offset 0 and 4'b0011 at offset 2. Register bits [15:0] are repeated in both halfword positions of the write data.
- R9: A word store drives all four strobes and passes the register value through unchanged.
- R10: A halfword with offset bit 0 set, a word with a nonzero offset, and any access of size code 3 each raise `rsp_misalign`. Such an access returns zero strobes, zero write data and zero load data. A byte access is never misaligned.
- R11: A load drives no strobes and zero write data. A store returns zero load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend load result |
| req_offset | input | 2 | Byte offset of the effective address within the word |
| mem_rdata | input | 32 | Word fetched from memory for a load |
| reg_wdata | input | 32 | Register value for a store |
| rsp_valid | output | 1 | Registered response present |
| rsp_misalign | output | 1 | Misaligned or reserved-size access |
| rsp_load_data | output | 32 | Extracted and extended load value |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_wstrb | output | 4 | Byte write strobes, bit 3 = offset 0 |

## Verification
The bench goes after lane ordering. A little-endian slip would return 0x34 instead of 0xAB for an unsigned byte at offset 0, and would strobe bit 0 instead of bit 3. It checks extension on bytes whose top bit is set. A design that ignores the signed flag would return 0x000000CD where 0xFFFFFFCD is due. It also drives every size at every offset. An aligner that misses the offset-bit-0 case for halfwords, or the reserved size, would write memory with a live strobe where none is allowed. Word loads with the signed flag set confirm that the flag does not disturb a full-width result.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] offset,
    output logic             misaligned
);

    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = offset[0];
            SZ_WORD: misaligned = |offset;
            default: misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic              sign_ext,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] value
);

    logic [OFF_W-1:0]  off_even;
    logic [DATA_W-1:0] byte_shift;
    logic [DATA_W-1:0] half_shift;
    logic [7:0]        byte_val;
    logic [15:0]       half_val;

    // big-endian: offset 0 lives in the top lane, so shift down by the lanes below it
    always_comb begin
        off_even   = {offset[OFF_W-1:1], 1'b0};
        byte_shift = word >> (8 * (LANES - 1 - int'(offset)));
        half_shift = word >> (8 * (LANES - 2 - int'(off_even)));
        byte_val   = byte_shift[7:0];
        half_val   = half_shift[15:0];
        unique case (size)
            SZ_BYTE: value = {{(DATA_W-8){sign_ext & byte_val[7]}}, byte_val};
            SZ_HALF: value = {{(DATA_W-16){sign_ext & half_val[15]}}, half_val};
            default: value = word;
        endcase
    end

endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lane_data,
    output logic [LANES-1:0]  lane_en
);

    logic [LANES-1:0]  en_byte;
    logic [LANES-1:0]  en_half;
    logic [DATA_W-1:0] rep_byte;
    logic [DATA_W-1:0] rep_half;
    logic [OFF_W-1:0]  off_even;

    assign off_even = {offset[OFF_W-1:1], 1'b0};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // lane g carries address offset LANES-1-g
        localparam logic [OFF_W-1:0] LANE_OFF  = OFF_W'(LANES - 1 - g);
        localparam logic [OFF_W-1:0] LANE_EVEN = {LANE_OFF[OFF_W-1:1], 1'b0};
        assign en_byte[g]        = (offset == LANE_OFF);
        assign en_half[g]        = (off_even == LANE_EVEN);
        assign rep_byte[8*g +: 8] = wdata[7:0];
        if (g % 2 == 1) begin : g_hi
            assign rep_half[8*g +: 8] = wdata[15:8];
        end else begin : g_lo
            assign rep_half[8*g +: 8] = wdata[7:0];
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                lane_data = rep_byte;
                lane_en   = en_byte;
            end
            SZ_HALF: begin
                lane_data = rep_half;
                lane_en   = en_half;
            end
            default: begin
                lane_data = wdata;
                lane_en   = '1;
            end
        endcase
    end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              rsp_valid,
    output logic              rsp_misalign,
    output logic [DATA_W-1:0] rsp_load_data,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_wstrb
);

    typedef struct packed {
        logic              valid;
        logic              misalign;
        logic [DATA_W-1:0] ld;
        logic [DATA_W-1:0] wd;
        logic [LANES-1:0]  be;
    } rsp_t;

    acc_size_e         size;
    logic              bad;
    logic [DATA_W-1:0] ld_val;
    logic [DATA_W-1:0] st_val;
    logic [LANES-1:0]  st_en;
    rsp_t              rsp_d, rsp_q;

    assign size = acc_size_e'(req_size);

    lsu_align_check #(.OFF_W(OFF_W)) u_check (
        .size       (size),
        .offset     (req_offset),
        .misaligned (bad)
    );

    lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_load (
        .size     (size),
        .sign_ext (req_signed),
        .offset   (req_offset),
        .word     (mem_rdata),
        .value    (ld_val)
    );

    lsu_store_pack #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_store (
        .size      (size),
        .offset    (req_offset),
        .wdata     (reg_wdata),
        .lane_data (st_val),
        .lane_en   (st_en)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (bad) begin
                rsp_d.misalign = 1'b1;
            end else if (req_store) begin
                rsp_d.wd = st_val;
                rsp_d.be = st_en;
            end else begin
                rsp_d.ld = ld_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_misalign  = rsp_q.misalign;
    assign rsp_load_data = rsp_q.ld;
    assign mem_wdata     = rsp_q.wd;
    assign mem_wstrb     = rsp_q.be;

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && mem_wstrb == '0 && rsp_load_data == '0));

    // R10
    misalign_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_misalign |-> (mem_wstrb == '0 && rsp_valid));

    // R7
    byte_store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd0) |=> ($countones(mem_wstrb) == 1));

    // R8
    half_store_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd1 && !req_offset[0])
            |=> ($countones(mem_wstrb) == 2));

    // R11
    load_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |=> (mem_wstrb == '0));

    // R3
    unsigned_byte_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && !req_signed && req_size == 2'd0)
            |=> (rsp_load_data[DATA_W-1:8] == '0));

endmodule

// File: tb/lsu_align_unit_test.sv
`timescale 1ns/1ps
module lsu_align_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_signed;
    logic [1:0]  req_size, req_offset;
    logic [31:0] mem_rdata, reg_wdata;
    logic        rsp_valid, rsp_misalign;
    logic [31:0] rsp_load_data, mem_wdata;
    logic [3:0]  mem_wstrb;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lsu_align_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_signed(req_signed), .req_offset(req_offset),
        .mem_rdata(mem_rdata), .reg_wdata(reg_wdata), .rsp_valid(rsp_valid),
        .rsp_misalign(rsp_misalign), .rsp_load_data(rsp_load_data),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb)
    );

    typedef struct {
        bit          v;
        bit          e;
        logic [31:0] ld;
        logic [31:0] wd;
        logic [3:0]  be;
        string       ld_tag;
        string       st_tag;
    } exp_t;

    exp_t pend[$];

    function automatic exp_t model(bit v, bit st, logic [1:0] sz, bit sgn,
                                   logic [1:0] off, logic [31:0] m, logic [31:0] w);
        exp_t r;
        logic [7:0]  ln [4];
        logic [7:0]  b;
        logic [15:0] h;
        bit          bad;
        r.v = v; r.e = 0; r.ld = 0; r.wd = 0; r.be = 0;
        r.ld_tag = "R2"; r.st_tag = "R2";
        if (!v) return r;
        ln[0] = m[31:24]; ln[1] = m[23:16]; ln[2] = m[15:8]; ln[3] = m[7:0];
        bad = (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0);
        if (bad) begin
            r.e = 1; r.ld_tag = "R10"; r.st_tag = "R10";
            return r;
        end
        if (!st) begin
            r.st_tag = "R11";
            case (sz)
                2'd0: begin
                    b = ln[off];
                    r.ld = sgn ? {{24{b[7]}}, b} : {24'h0, b};
                    r.ld_tag = sgn ? "R4" : "R3";
                end
                2'd1: begin
                    h = {ln[off], ln[off + 2'd1]};
                    r.ld = sgn ? {{16{h[15]}}, h} : {16'h0, h};
                    r.ld_tag = sgn ? "R5/R4" : "R5";
                end
                default: begin
                    r.ld = m; r.ld_tag = "R6";
                end
            endcase
        end else begin
            r.ld_tag = "R11";
            case (sz)
                2'd0: begin r.be = 4'b1000 >> off; r.wd = {4{w[7:0]}}; r.st_tag = "R7"; end
                2'd1: begin r.be = (off == 0) ? 4'b1100 : 4'b0011; r.wd = {2{w[15:0]}}; r.st_tag = "R8"; end
                default: begin r.be = 4'b1111; r.wd = w; r.st_tag = "R9"; end
            endcase
        end
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_pending();
        exp_t x;
        if (pend.size() == 0) return;
        x = pend.pop_front();
        chk("R2",     "valid",  {31'h0, rsp_valid},    {31'h0, x.v});
        chk("R10",    "misal",  {31'h0, rsp_misalign}, {31'h0, x.e});
        chk(x.ld_tag, "ldata",  rsp_load_data,         x.ld);
        chk(x.st_tag, "wdata",  mem_wdata,             x.wd);
        chk(x.st_tag, "wstrb",  {28'h0, mem_wstrb},    {28'h0, x.be});
    endtask

    // one request per cycle, driven and checked at the falling edge
    task automatic step(bit v, bit st, logic [1:0] sz, bit sgn, logic [1:0] off,
                        logic [31:0] m, logic [31:0] w);
        @(negedge clk);
        compare_pending();
        req_valid = v; req_store = st; req_size = sz; req_signed = sgn;
        req_offset = off; mem_rdata = m; reg_wdata = w;
        pend.push_back(model(v, st, sz, sgn, off, m, w));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 1; req_store = 1; req_size = 2'd2; req_signed = 0;
        req_offset = 0; mem_rdata = 32'hFFFF_FFFF; reg_wdata = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs held at zero under reset despite an active request
        chk("R1", "valid", {31'h0, rsp_valid}, 32'h0);
        chk("R1", "ldata", rsp_load_data, 32'h0);
        chk("R1", "wstrb", {28'h0, mem_wstrb}, 32'h0);
        chk("R1", "wdata", mem_wdata, 32'h0);
        req_valid = 0;
        rst_n = 1;

        // R3 R4 R5: big-endian lane pick on 0xABCD1234
        step(1, 0, 2'd1, 1, 2'd2, 32'hABCD_1234, 0);  // -> 00001234
        step(1, 0, 2'd0, 1, 2'd1, 32'hABCD_1234, 0);  // -> FFFFFFCD
        step(1, 0, 2'd0, 0, 2'd0, 32'hABCD_1234, 0);  // -> 000000AB
        step(1, 0, 2'd0, 0, 2'd1, 32'hABCD_1234, 0);  // -> 000000CD
        step(1, 0, 2'd1, 1, 2'd0, 32'hABCD_1234, 0);  // -> FFFFABCD
        step(1, 0, 2'd1, 0, 2'd0, 32'hABCD_1234, 0);  // -> 0000ABCD
        // R6: signed flag leaves a word untouched
        step(1, 0, 2'd2, 1, 2'd0, 32'h8001_0203, 0);
        // R8 R7: halfword 0xBEEF at offset 0, byte 0xEF at offset 3
        step(1, 1, 2'd1, 0, 2'd0, 0, 32'hDEAD_BEEF);
        step(1, 1, 2'd0, 1, 2'd3, 0, 32'hDEAD_BEEF);
        step(1, 1, 2'd0, 0, 2'd0, 0, 32'h0000_005A);
        step(1, 1, 2'd1, 0, 2'd2, 0, 32'h1234_5678);
        // R9
        step(1, 1, 2'd2, 0, 2'd0, 0, 32'hCAFE_F00D);
        // R10: misaligned half, word, reserved size
        step(1, 1, 2'd1, 0, 2'd1, 0, 32'hFFFF_FFFF);
        step(1, 1, 2'd2, 0, 2'd2, 0, 32'hFFFF_FFFF);
        step(1, 0, 2'd3, 0, 2'd0, 32'hFFFF_FFFF, 0);
        step(1, 0, 2'd1, 1, 2'd3, 32'hFFFF_FFFF, 0);
        // R2: idle after traffic
        step(0, 1, 2'd2, 0, 2'd0, 32'h1111_1111, 32'h2222_2222);

        for (int i = 0; i < 400; i++) begin
            step($urandom_range(0, 7) != 0, $urandom_range(0, 1), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 1), 2'($urandom_range(0, 3)), $urandom, $urandom);
        end
        step(0, 0, 2'd0, 0, 2'd0, 0, 0);
        @(negedge clk);
        compare_pending();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule